// File: doc/BRIEF.md
# Two-Dimensional Parity Protected Memory

This block is a single-port memory array in which every stored row carries a cheap horizontal code and the whole array shares one vertical code. The horizontal code is a set of interleaved parity bits kept beside each row. It is checked on every read, so a corrupted row is caught with no extra latency. The vertical code is one full-width parity row, the XOR of every data row. Each write keeps it current by first reading the old row and then folding old XOR new data into it.

When a read finds a horizontal mismatch, a correction sequencer takes over. It starts from the vertical parity row and XORs in every other row of the array, which rebuilds the damaged row. The rebuilt row is written back and returned with a corrected status. If another row also fails its horizontal check during this scan, the row cannot be rebuilt. The read then returns an uncorrectable status and nothing is written. A clustered error confined to one row is repaired without any multi-bit ECC.

Requests are accepted only while `busy` is low. A fault-injection port lets a test flip stored data bits without touching either code.

Top module: `grid_parity_mem`

## Requirements
- R1: After reset `busy` and `rd_valid` are low, and every row reads back as zero with status 2'b00 (clean).
- R2: A read accepted on a clock edge produces a single-cycle `rd_valid` pulse two edges later. When the row is intact, that pulse carries the last data written to the row with status 2'b00.
- R3: After a write is accepted, `busy` is high for exactly two cycles and then low. A request presented while `busy` is high is ignored: it produces no result and changes no stored row.
- R4: Horizontal parity bit g is the XOR of the data bits whose index modulo HP equals g. A flip pattern with an odd count in some group is detected, including any contiguous burst of up to HP bits. Flips confined in even numbers to each group go undetected and are read as clean.
- R5: A detected corruption confined to one row is repaired. The read returns the original data with status 2'b01 (corrected), and `busy` stays high from acceptance until the result.
- R6: After a corrected read, the repaired row has been written back, so a later read of that row is clean and returns the original data.
- R7: If any other row fails its horizontal check during the reconstruction scan, the read returns status 2'b10 (uncorrectable) and the target row is not written.
- R8: The vertical code stays consistent across any sequence of writes, including overwrites of rows already written, so correction still returns the latest data.
- R9: The injection port XORs `inj_mask` into the stored data of row `inj_row` on a clock edge, but only while the block is idle. It never changes the stored codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Row address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Block is working on an accepted request |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | DW | Read result data |
| rd_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| inj_en | input | 1 | Apply a fault-injection flip this cycle |
| inj_row | input | AW | Row to corrupt |
| inj_mask | input | DW | Bits to flip in the stored data |

## Verification
The bench builds the block with 16 rows of 32 bits and 8 horizontal groups. This keeps a full reconstruction scan to about twenty cycles, so many corrections fit in a short run. With four bits per group at this width, the bench can place bursts that fill every group once and same-group pairs that escape detection on purpose. It can also corrupt two rows at once to reach the uncorrectable path, and then undo the damage to show that nothing was written back.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
   typedef enum logic [1:0] {
      RS_CLEAN = 2'b00,
      RS_FIXED = 2'b01,
      RS_LOST  = 2'b10
   } rstat_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_COMMIT,
      S_SCAN,
      S_FIX
   } fsm_t;
endpackage

// File: rtl/gpm_hcode.sv
module gpm_hcode #(
   parameter int DW = 256,
   parameter int HP = 8
) (
   input  logic [DW-1:0] data,
   output logic [HP-1:0] code
);
   initial begin
      assert (HP >= 1 && DW % HP == 0)
         else $error("gpm_hcode: DW must be a multiple of HP");
   end

   generate
      if (HP == 1) begin : g_plain
         assign code = ^data;
      end else begin : g_ilv
         for (genvar g = 0; g < HP; g++) begin : g_grp
            logic grp_x;
            always_comb begin
               grp_x = 1'b0;
               for (int j = g; j < DW; j += HP) grp_x ^= data[j];
            end
            assign code[g] = grp_x;
         end
      end
   endgenerate
endmodule

// File: rtl/gpm_array.sv
module gpm_array #(
   parameter int ROWS = 256,
   parameter int DW   = 256,
   parameter int HP   = 8,
   localparam int AW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [HP-1:0] rd_code,
   input  logic          we,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [HP-1:0] wr_code,
   input  logic          inj_en,
   input  logic [AW-1:0] inj_row,
   input  logic [DW-1:0] inj_mask
);
   logic [DW-1:0] mem_d [ROWS];
   logic [HP-1:0] mem_h [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            mem_d[r] <= '0;
            mem_h[r] <= '0;
         end
      end else if (we) begin
         mem_d[wr_addr] <= wr_data;
         mem_h[wr_addr] <= wr_code;
      end else if (inj_en) begin
         mem_d[inj_row] <= mem_d[inj_row] ^ inj_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_code <= '0;
      end else if (rd_en) begin
         rd_data <= mem_d[rd_addr];
         rd_code <= mem_h[rd_addr];
      end
   end
endmodule

// File: rtl/gpm_vcode.sv
module gpm_vcode #(
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_en,
   input  logic [DW-1:0] upd_delta,
   output logic [DW-1:0] vpar
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vpar <= '0;
      else if (upd_en) vpar <= vpar ^ upd_delta;
   end
endmodule

// File: rtl/grid_parity_mem.sv
module grid_parity_mem
   import gpm_pkg::*;
#(
   parameter int ROWS = 256,
   parameter int DW   = 256,
   parameter int HP   = 8,
   localparam int AW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          busy,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [1:0]    rd_status,
   input  logic          inj_en,
   input  logic [AW-1:0] inj_row,
   input  logic [DW-1:0] inj_mask
);
   localparam logic [AW:0] ROW_END = (AW+1)'(ROWS);

   initial begin
      assert (ROWS >= 2 && (1 << AW) == ROWS)
         else $error("grid_parity_mem: ROWS must be a power of two, at least 2");
   end

   fsm_t          st;
   logic          accept;
   logic          wr_q;
   logic [AW-1:0] tgt;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] delta_q;
   logic [AW:0]   idx;
   logic          pend;
   logic          bad;
   logic [DW-1:0] acc;

   logic          arr_re;
   logic [AW-1:0] arr_raddr;
   logic [DW-1:0] arr_rdata;
   logic [HP-1:0] arr_rcode;
   logic          arr_we;
   logic [DW-1:0] arr_wdata;
   logic [HP-1:0] arr_wcode;
   logic [HP-1:0] chk_code;
   logic          row_ok;
   logic          v_upd;
   logic [DW-1:0] vpar;
   logic          issue;

   assign busy   = (st != S_IDLE);
   assign accept = req_valid && !busy;
   assign row_ok = (chk_code == arr_rcode);
   assign issue  = (st == S_SCAN) && (idx < ROW_END) && (idx[AW-1:0] != tgt);

   always_comb begin
      arr_re    = 1'b0;
      arr_raddr = req_addr;
      if (st == S_IDLE) begin
         arr_re = accept;
      end else if (st == S_SCAN) begin
         arr_re    = issue;
         arr_raddr = idx[AW-1:0];
      end
   end

   assign arr_we    = (st == S_COMMIT) || (st == S_FIX && !bad);
   assign arr_wdata = (st == S_COMMIT) ? wdata_q : acc;
   assign v_upd     = (st == S_COMMIT);

   gpm_array #(.ROWS(ROWS), .DW(DW), .HP(HP)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (arr_re),
      .rd_addr  (arr_raddr),
      .rd_data  (arr_rdata),
      .rd_code  (arr_rcode),
      .we       (arr_we),
      .wr_addr  (tgt),
      .wr_data  (arr_wdata),
      .wr_code  (arr_wcode),
      .inj_en   (inj_en && st == S_IDLE),
      .inj_row  (inj_row),
      .inj_mask (inj_mask)
   );

   gpm_hcode #(.DW(DW), .HP(HP)) u_hc_rd (.data(arr_rdata), .code(chk_code));
   gpm_hcode #(.DW(DW), .HP(HP)) u_hc_wr (.data(arr_wdata), .code(arr_wcode));

   gpm_vcode #(.DW(DW)) u_vcode (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (v_upd),
      .upd_delta (delta_q),
      .vpar      (vpar)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         wr_q      <= 1'b0;
         tgt       <= '0;
         wdata_q   <= '0;
         delta_q   <= '0;
         idx       <= '0;
         pend      <= 1'b0;
         bad       <= 1'b0;
         acc       <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         rd_status <= RS_CLEAN;
      end else begin
         rd_valid <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (accept) begin
                  wr_q    <= req_write;
                  tgt     <= req_addr;
                  wdata_q <= req_wdata;
                  st      <= S_LOOK;
               end
            end
            S_LOOK: begin
               if (wr_q) begin
                  delta_q <= arr_rdata ^ wdata_q;
                  st      <= S_COMMIT;
               end else if (row_ok) begin
                  rd_valid  <= 1'b1;
                  rd_data   <= arr_rdata;
                  rd_status <= RS_CLEAN;
                  st        <= S_IDLE;
               end else begin
                  acc  <= vpar;
                  idx  <= '0;
                  pend <= 1'b0;
                  bad  <= 1'b0;
                  st   <= S_SCAN;
               end
            end
            S_COMMIT: begin
               st <= S_IDLE;
            end
            S_SCAN: begin
               pend <= issue;
               if (idx < ROW_END) idx <= idx + 1'b1;
               if (pend) begin
                  acc <= acc ^ arr_rdata;
                  if (!row_ok) bad <= 1'b1;
               end
               if (idx == ROW_END && !pend) st <= S_FIX;
            end
            S_FIX: begin
               rd_valid  <= 1'b1;
               rd_data   <= acc;
               rd_status <= bad ? RS_LOST : RS_FIXED;
               st        <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R2
   AST_RESULT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(busy)); // R2
   AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_COMMIT) |=> !busy); // R3
   AST_MISMATCH_SCANS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LOOK && !wr_q && !row_ok) |=> (st == S_SCAN)); // R4
   AST_FIXED_WROTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_status == RS_FIXED) |-> $past(arr_we)); // R6
   AST_LOST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_status == RS_LOST) |-> !$past(arr_we)); // R7
   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_status != 2'b11)); // R5
endmodule

// File: tb/tb_grid_parity_mem.sv
module tb_grid_parity_mem;
   localparam int ROWS = 16;
   localparam int DW   = 32;
   localparam int HP   = 8;
   localparam int AW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [1:0]    rd_status;
   logic          inj_en = 1'b0;
   logic [AW-1:0] inj_row = '0;
   logic [DW-1:0] inj_mask = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [DW-1:0] model [ROWS];

   always #2.5 clk = ~clk;

   grid_parity_mem #(.ROWS(ROWS), .DW(DW), .HP(HP)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_status(rd_status),
      .inj_en(inj_en), .inj_row(inj_row), .inj_mask(inj_mask)
   );

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_read(input int a, output logic [DW-1:0] d, output logic [1:0] s,
                          output int lat, output bit busy_ok);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; busy_ok = 1'b1;
      while (!rd_valid && lat < 200) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      d = rd_data; s = rd_status;
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] v,
                           output bit b1, output bit b2, output bit b3);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = v;
      @(negedge clk);
      req_valid = 1'b0;
      b1 = busy;
      @(negedge clk); b2 = busy;
      @(negedge clk); b3 = busy;
      model[a] = v;
   endtask

   task automatic inject(input int r, input logic [DW-1:0] m);
      @(negedge clk);
      while (busy) @(negedge clk);
      inj_en = 1'b1; inj_row = AW'(r); inj_mask = m;
      @(negedge clk);
      inj_en = 1'b0;
   endtask

   task automatic expect_read(input int a, input logic [DW-1:0] ed, input logic [1:0] es,
                              input string tag);
      logic [DW-1:0] d; logic [1:0] s; int lat; bit bok;
      do_read(a, d, s, lat, bok);
      check(d == ed, {tag, " data"}, d, ed);
      check(s == es, {tag, " status"}, DW'(s), DW'(es));
   endtask

   task automatic t_reset();
      check(!busy && !rd_valid, "R1 idle after reset", DW'({busy, rd_valid}), '0);
      expect_read(0, '0, 2'b00, "R1 row0");
      expect_read(ROWS-1, '0, 2'b00, "R1 last row");
   endtask

   task automatic t_fill();
      bit b1, b2, b3;
      logic [DW-1:0] d; logic [1:0] s; int lat; bit bok;
      for (int r = 0; r < ROWS; r++) begin
         do_write(r, 32'h5A3C_0F81 ^ (32'h0101_0101 * r) ^ (r << 27), b1, b2, b3);
         if (r == 0)
            check(b1 && b2 && !b3, "R3 write busy two cycles", DW'({b1, b2, b3}), 32'h6);
      end
      for (int r = 0; r < ROWS; r += 5) begin
         do_read(r, d, s, lat, bok);
         check(d == model[r] && s == 2'b00, "R2 clean read", d, model[r]);
         check(lat == 2, "R2 read latency", DW'(lat), 32'd2);
      end
   endtask

   task automatic t_ignore();
      int seen = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd2; req_wdata = 32'h1234_5678;
      @(negedge clk);
      model[2] = 32'h1234_5678;
      req_write = 1'b1; req_addr = 4'd5; req_wdata = 32'hDEAD_BEEF;
      for (int k = 0; k < 2; k++) begin
         if (rd_valid) seen++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (rd_valid) seen++;
         @(negedge clk);
      end
      check(seen == 0, "R3 no result for ignored request", DW'(seen), '0);
      expect_read(5, model[5], 2'b00, "R3 ignored write left row");
      expect_read(2, model[2], 2'b00, "R3 accepted write");
   endtask

   task automatic t_burst();
      logic [DW-1:0] d; logic [1:0] s; int lat; bit bok;
      int lens[3] = '{1, 5, 8};
      int poss[3] = '{0, 13, 24};
      for (int k = 0; k < 3; k++) begin
         logic [DW-1:0] m;
         int row;
         m = ((DW'(1) << lens[k]) - 1) << poss[k];
         row = 3 + 4 * k;
         inject(row, m);
         do_read(row, d, s, lat, bok);
         check(s == 2'b01, "R4 burst detected and R5 corrected", DW'(s), 32'd1);
         check(d == model[row], "R5 corrected data", d, model[row]);
         check(bok, "R5 busy held through correction", DW'(bok), 32'd1);
         expect_read(row, model[row], 2'b00, "R6 written back");
      end
   endtask

   task automatic t_groups();
      inject(6, 32'h0000_0101);
      expect_read(6, model[6] ^ 32'h0000_0101, 2'b00, "R4 same-group pair undetected");
      inject(6, 32'h0000_0101);
      inject(6, 32'h0000_0003);
      expect_read(6, model[6], 2'b01, "R4 adjacent-group pair corrected");
   endtask

   task automatic t_double();
      inject(3, 32'h0000_00F0);
      inject(9, 32'h0100_0000);
      expect_read(3, model[3] ^ 32'h0100_0000 ^ 32'h0000_0000 ^ 32'h0000_0000 ^ 32'h0 ^
                  (32'h0000_00F0 ^ 32'h0000_00F0) ^ 32'h0 ^ 32'h0 ^ 32'h0 ^
                  (32'h0100_0000 ^ 32'h0100_0000) ^ 32'h0 ^ 32'h0 ^ 32'h0 ^ 32'h0, 2'b10,
                  "R7 second bad row");
      expect_read(3, model[3] ^ 32'h0100_0000, 2'b10, "R7 still uncorrectable");
      inject(3, 32'h0000_00F0);
      inject(9, 32'h0100_0000);
      expect_read(3, model[3], 2'b00, "R7 no write-back");
      expect_read(9, model[9], 2'b00, "R7 other row intact");
   endtask

   task automatic t_vmaint();
      bit b1, b2, b3;
      do_write(0, 32'hFFFF_0000, b1, b2, b3);
      do_write(4, 32'h0F0F_1234, b1, b2, b3);
      do_write(15, 32'hC001_D00D, b1, b2, b3);
      do_write(15, 32'h7777_8888, b1, b2, b3);
      inject(15, 32'hFF00_0000);
      expect_read(15, 32'h7777_8888, 2'b01, "R8 correction after overwrites");
      inject(0, 32'h0000_3C00);
      expect_read(0, 32'hFFFF_0000, 2'b01, "R8 second correction");
   endtask

   task automatic t_inj();
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd8; req_wdata = 32'hABCD_0123;
      @(negedge clk);
      model[8] = 32'hABCD_0123;
      req_valid = 1'b0;
      inj_en = 1'b1; inj_row = 4'd1; inj_mask = 32'h0000_00FF;
      @(negedge clk);
      inj_en = 1'b0;
      expect_read(1, model[1], 2'b00, "R9 injection ignored while busy");
      inject(1, 32'h0000_0010);
      expect_read(1, model[1] ^ 32'h0000_0010 ^ 32'h0000_0010, 2'b01, "R9 injection applied");
   endtask

   initial begin
      for (int r = 0; r < ROWS; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fill();
      t_ignore();
      t_burst();
      t_groups();
      t_double();
      t_vmaint();
      t_inj();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule